// File: doc/BRIEF.md
# Burst Rectangle Blitter with Blend and Tiling

This block moves full-colour pixels inside one shared pixel RAM. It has three read channels (A, B, C) and one write channel (D). Each channel walks its own rectangle: a base address, a row width in pixels, a row pitch (stride) and a pixel count. Software sets the channel fields, the enable mask and the mode bits, then pulses `start`. The engine copies A to D, fills D with a constant colour, tiles a short source across a longer destination, or blends C toward B under a per-component alpha taken from A.

The engine works in batches. It requests the memory port and waits for the grant. It then reads one batch of pixels for every enabled read channel, waits for the last read data to return, and writes the same number of pixels to D in one burst. After that it drops its request for at least one cycle so that other requesters can use the port. A serial mode shortens each batch to one pixel. This keeps a copy correct when the source and destination overlap by a few pixels.

Top module: `blit_engine`

## Requirements
- R1: After reset, `busy`, `done`, `done_pulse`, `mem_req`, `mem_rd` and `mem_we` are all low.
- R2: With only D enabled (`ch_en` = 4'b1000), every D pixel is written with `fill_color`, and exactly `chan_count[3]` writes are made.
- R3: Each channel visits its pixels in raster order. The address rises by 1 per pixel, and after `chan_width` pixels it moves to the previous row start plus `chan_stride`. Pixel k of D receives pixel k of A (A = `ch_en[0]`), even when the two widths and strides differ.
- R4: A read channel whose pixel count is used up restarts at its base address, so D pixel k takes source pixel k mod that channel's count.
- R5: With `blend_en` set, each 8-bit component i (bits 8i+7:8i) of a D pixel is (a*b + (255-a)*c) >> 8. Here a, b and c are component i of the matching A, B and C pixels.
- R6: A batch covers min(16, remaining D pixels) pixels, or 1 pixel in serial mode. All reads of a batch (channels in order A, B, C) come before any of its writes, and a burst of writes has at most 16 pixels.
- R7: `mem_rd` and `mem_we` are raised only while `mem_req` and `mem_gnt` are both high. When a write burst ends, `mem_req` is low in the following cycle.
- R8: In serial mode (`serial_mode` = 1), each pixel is written before the next pixel is read. A copy with D base = A base + 1 therefore replicates the first A pixel. In batch mode the same copy of at most 16 pixels moves the original A pixels.
- R9: When the last D pixel has been written, `done_pulse` is high for exactly one cycle, `busy` falls, and `done` stays high until the next accepted `start`.
- R10: A start with D disabled or `chan_count[3]` = 0 finishes at once: `done_pulse` follows in the next cycle and no memory access is made.
- R11: A `start` that arrives while `busy` is high is ignored, and the running job completes with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a job when idle |
| ch_en | input | 4 | Channel enables: bit0 A, bit1 B, bit2 C, bit3 D |
| blend_en | input | 1 | Blend mode select |
| serial_mode | input | 1 | One pixel per batch |
| fill_color | input | PIX_W | Constant written when A is disabled and blend is off |
| chan_base | input | 4 x ADDR_W | Base address per channel |
| chan_width | input | 4 x CNT_W | Row width in pixels per channel |
| chan_stride | input | 4 x ADDR_W | Row pitch per channel |
| chan_count | input | 4 x CNT_W | Pixel count per channel (D count is the job length) |
| busy | output | 1 | Job in progress |
| done | output | 1 | Sticky completion flag |
| done_pulse | output | 1 | One-cycle completion strobe |
| mem_req | output | 1 | Memory port request |
| mem_gnt | input | 1 | Memory port grant, held while the request stays high |
| mem_rd | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Pixel address |
| mem_wdata | output | PIX_W | Write pixel |
| mem_rdata | input | PIX_W | Read pixel, valid RD_LAT cycles after `mem_rd` |

## Verification
The assertions assume that once the arbiter raises `mem_gnt`, it keeps it high for as long as `mem_req` stays high. They also assume that read data returns exactly RD_LAT cycles after the strobe and that every channel width is at least one. The bench arbiter grants only while the request is high and holds the grant until the request drops. Its memory model returns data on a two-cycle pipeline. All random widths start at one, and random regions never overlap except in the two directed overlap cases.

// File: rtl/blit_pkg.sv
package blit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_DRAIN,
        ST_WR,
        ST_REL
    } blit_state_e;

    localparam int NUM_CH = 4;
    localparam int CH_D   = 3;

    // Lowest enabled read channel index >= from; 3 means none left.
    function automatic logic [1:0] first_rd_ch(input logic [3:0] en, input logic [2:0] from);
        logic [1:0] r;
        r = 2'd3;
        for (int c = 2; c >= 0; c--) begin
            if (c >= int'(from) && en[c]) r = 2'(c);
        end
        return r;
    endfunction

endpackage

// File: rtl/blit_chan_addr.sv
module blit_chan_addr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter bit WRAP   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  width,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  remain,
    output logic              last
);

    typedef struct packed {
        logic [ADDR_W-1:0] cfg_base;
        logic [CNT_W-1:0]  cfg_width;
        logic [ADDR_W-1:0] cfg_stride;
        logic [CNT_W-1:0]  cfg_count;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] row;
        logic [CNT_W-1:0]  col;
        logic [CNT_W-1:0]  remain;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (load) begin
            w_d.cfg_base   = base;
            w_d.cfg_width  = width;
            w_d.cfg_stride = stride;
            w_d.cfg_count  = count;
            w_d.addr       = base;
            w_d.row        = base;
            w_d.col        = '0;
            w_d.remain     = count;
        end else if (step) begin
            if (WRAP && w_q.remain == CNT_W'(1)) begin
                // source exhausted: restart at its base (tiling)
                w_d.addr   = w_q.cfg_base;
                w_d.row    = w_q.cfg_base;
                w_d.col    = '0;
                w_d.remain = w_q.cfg_count;
            end else begin
                if (w_q.remain != '0) w_d.remain = w_q.remain - CNT_W'(1);
                if (w_q.col + CNT_W'(1) >= w_q.cfg_width) begin
                    w_d.row  = w_q.row + w_q.cfg_stride;
                    w_d.addr = w_q.row + w_q.cfg_stride;
                    w_d.col  = '0;
                end else begin
                    w_d.addr = w_q.addr + ADDR_W'(1);
                    w_d.col  = w_q.col + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign addr   = w_q.addr;
    assign remain = w_q.remain;
    assign last   = (w_q.remain == CNT_W'(1));

endmodule

// File: rtl/blit_blend.sv
module blit_blend #(
    parameter int PIX_W  = 24,
    parameter int COMP_W = 8
) (
    input  logic [PIX_W-1:0] alpha_pix,
    input  logic [PIX_W-1:0] toward_pix,
    input  logic [PIX_W-1:0] target_pix,
    output logic [PIX_W-1:0] result
);

    localparam int NCOMP = PIX_W / COMP_W;
    localparam int PW    = 2 * COMP_W;

    for (genvar i = 0; i < NCOMP; i++) begin : g_comp
        logic [COMP_W-1:0] a, b, c, inv;
        logic [PW-1:0]     mix;
        assign a   = alpha_pix [i*COMP_W +: COMP_W];
        assign b   = toward_pix[i*COMP_W +: COMP_W];
        assign c   = target_pix[i*COMP_W +: COMP_W];
        assign inv = ~a;
        assign mix = (PW'(a) * PW'(b)) + (PW'(inv) * PW'(c));
        assign result[i*COMP_W +: COMP_W] = mix[PW-1:COMP_W];
    end

    if (NCOMP * COMP_W < PIX_W) begin : g_pad
        assign result[PIX_W-1:NCOMP*COMP_W] = '0;
    end

endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int PIX_W  = 24,
    parameter int COMP_W = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int BURST  = 16,
    parameter int RD_LAT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [3:0]                  ch_en,
    input  logic                        blend_en,
    input  logic                        serial_mode,
    input  logic [PIX_W-1:0]            fill_color,
    input  logic [3:0][ADDR_W-1:0]      chan_base,
    input  logic [3:0][CNT_W-1:0]       chan_width,
    input  logic [3:0][ADDR_W-1:0]      chan_stride,
    input  logic [3:0][CNT_W-1:0]       chan_count,
    output logic                        busy,
    output logic                        done,
    output logic                        done_pulse,
    output logic                        mem_req,
    input  logic                        mem_gnt,
    output logic                        mem_rd,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [PIX_W-1:0]            mem_wdata,
    input  logic [PIX_W-1:0]            mem_rdata
);

    localparam int IW = $clog2(BURST + 1);
    localparam int BW = $clog2(BURST);

    typedef struct packed {
        blit_state_e      st;
        logic [1:0]       ch;
        logic [IW-1:0]    idx;
        logic [IW-1:0]    n;
        logic [3:0]       en;
        logic             blend;
        logic             serial;
        logic [PIX_W-1:0] fill;
        logic             done;
        logic             pulse;
    } ctl_t;

    ctl_t c_d, c_q;

    // channel address walkers
    logic [3:0]                 g_load, g_step, g_last;
    logic [3:0][ADDR_W-1:0]     g_addr;
    logic [3:0][CNT_W-1:0]      g_rem;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_walk
        blit_chan_addr #(
            .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WRAP(i != CH_D)
        ) u_walk (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (g_load[i]),
            .step   (g_step[i]),
            .base   (chan_base[i]),
            .width  (chan_width[i]),
            .stride (chan_stride[i]),
            .count  (chan_count[i]),
            .addr   (g_addr[i]),
            .remain (g_rem[i]),
            .last   (g_last[i])
        );
    end

    // read-return tracking line
    logic                     push_v;
    logic [1:0]               push_ch;
    logic [IW-1:0]            push_idx;
    logic [RD_LAT-1:0]        pv_q;
    logic [RD_LAT-1:0][1:0]   pch_q;
    logic [RD_LAT-1:0][IW-1:0] pidx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv_q   <= '0;
            pch_q  <= '0;
            pidx_q <= '0;
        end else begin
            pv_q[0]   <= push_v;
            pch_q[0]  <= push_ch;
            pidx_q[0] <= push_idx;
            for (int s = 1; s < RD_LAT; s++) begin
                pv_q[s]   <= pv_q[s-1];
                pch_q[s]  <= pch_q[s-1];
                pidx_q[s] <= pidx_q[s-1];
            end
        end
    end

    // per-channel batch buffers
    logic [PIX_W-1:0] buf_q [3][BURST];
    logic             cap_v;
    logic [1:0]       cap_ch;
    logic [BW-1:0]    cap_idx;

    assign cap_v   = pv_q[RD_LAT-1];
    assign cap_ch  = pch_q[RD_LAT-1];
    assign cap_idx = pidx_q[RD_LAT-1][BW-1:0];

    always_ff @(posedge clk) begin
        if (cap_v && cap_ch != 2'd3) buf_q[cap_ch][cap_idx] <= mem_rdata;
    end

    // result pixel for the current write slot
    logic [PIX_W-1:0] pix_a, pix_b, pix_c, pix_mix, pix_out;
    assign pix_a = buf_q[0][c_q.idx[BW-1:0]];
    assign pix_b = buf_q[1][c_q.idx[BW-1:0]];
    assign pix_c = buf_q[2][c_q.idx[BW-1:0]];

    blit_blend #(.PIX_W(PIX_W), .COMP_W(COMP_W)) u_blend (
        .alpha_pix  (pix_a),
        .toward_pix (pix_b),
        .target_pix (pix_c),
        .result     (pix_mix)
    );

    always_comb begin
        if (c_q.blend)      pix_out = pix_mix;
        else if (c_q.en[0]) pix_out = pix_a;
        else                pix_out = c_q.fill;
    end

    logic [1:0] nxt_ch;
    logic [IW-1:0] batch_n;

    always_comb begin
        nxt_ch = first_rd_ch(c_q.en, 3'(c_q.ch) + 3'd1);
        if (c_q.serial)                      batch_n = IW'(1);
        else if (g_rem[CH_D] < CNT_W'(BURST)) batch_n = IW'(g_rem[CH_D]);
        else                                 batch_n = IW'(BURST);
    end

    always_comb begin
        c_d       = c_q;
        c_d.pulse = 1'b0;
        g_load    = '0;
        g_step    = '0;
        push_v    = 1'b0;
        push_ch   = c_q.ch;
        push_idx  = c_q.idx;
        mem_req   = 1'b0;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    g_load     = 4'hF;
                    c_d.en     = ch_en;
                    c_d.blend  = blend_en;
                    c_d.serial = serial_mode;
                    c_d.fill   = fill_color;
                    if (!ch_en[CH_D] || chan_count[CH_D] == '0) begin
                        c_d.done  = 1'b1;
                        c_d.pulse = 1'b1;
                    end else begin
                        c_d.done = 1'b0;
                        c_d.st   = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    c_d.n   = batch_n;
                    c_d.idx = '0;
                    c_d.ch  = first_rd_ch(c_q.en, 3'd0);
                    c_d.st  = (first_rd_ch(c_q.en, 3'd0) == 2'd3) ? ST_WR : ST_RD;
                end
            end
            ST_RD: begin
                mem_req          = 1'b1;
                mem_rd           = 1'b1;
                mem_addr         = g_addr[c_q.ch];
                g_step[c_q.ch]   = 1'b1;
                push_v           = 1'b1;
                if (c_q.idx == c_q.n - IW'(1)) begin
                    c_d.idx = '0;
                    if (nxt_ch == 2'd3) c_d.st = ST_DRAIN;
                    else                c_d.ch = nxt_ch;
                end else begin
                    c_d.idx = c_q.idx + IW'(1);
                end
            end
            ST_DRAIN: begin
                mem_req = 1'b1;
                if (pv_q == '0) begin
                    c_d.idx = '0;
                    c_d.st  = ST_WR;
                end
            end
            ST_WR: begin
                mem_req        = 1'b1;
                mem_we         = 1'b1;
                mem_addr       = g_addr[CH_D];
                mem_wdata      = pix_out;
                g_step[CH_D]   = 1'b1;
                if (g_last[CH_D]) begin
                    c_d.done  = 1'b1;
                    c_d.pulse = 1'b1;
                    c_d.st    = ST_IDLE;
                end else if (c_q.idx == c_q.n - IW'(1)) begin
                    c_d.st = ST_REL;
                end else begin
                    c_d.idx = c_q.idx + IW'(1);
                end
            end
            ST_REL: begin
                c_d.st = ST_REQ;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy       = (c_q.st != ST_IDLE);
    assign done       = c_q.done;
    assign done_pulse = c_q.pulse;

endmodule

// File: rtl/blit_checker.sv
module blit_checker #(
    parameter int BURST = 16
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic done_pulse,
    input logic mem_req,
    input logic mem_gnt,
    input logic mem_rd,
    input logic mem_we
);

    logic [31:0] wr_run_q;
    logic        seen_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_run_q  <= '0;
            seen_wr_q <= 1'b0;
        end else begin
            wr_run_q  <= mem_we ? wr_run_q + 32'd1 : 32'd0;
            if (!mem_req)    seen_wr_q <= 1'b0;
            else if (mem_we) seen_wr_q <= 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !mem_rd && !mem_we));

    assert_burst_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_run_q < 32'(BURST)));

    assert_reads_before_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !seen_wr_q);

    assert_rd_wr_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));

    assert_access_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_we) |-> (mem_req && mem_gnt));

    assert_release_after_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> !mem_req);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (done && !busy));

endmodule

bind blit_engine blit_checker #(.BURST(BURST)) u_blit_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .done_pulse (done_pulse),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_rd     (mem_rd),
    .mem_we     (mem_we)
);

// File: tb/tb_blit_engine.sv
`timescale 1ns/1ps
module tb_blit_engine;

    localparam int AW = 12;
    localparam int PW = 24;
    localparam int CW = 16;
    localparam int MSZ = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                 start = 0;
    logic [3:0]           ch_en = 0;
    logic                 blend_en = 0, serial_mode = 0;
    logic [PW-1:0]        fill_color = 0;
    logic [3:0][AW-1:0]   chan_base = '0, chan_stride = '0;
    logic [3:0][CW-1:0]   chan_width = '0, chan_count = '0;
    logic busy, done, done_pulse, mem_req, mem_rd, mem_we;
    logic mem_gnt = 0;
    logic [AW-1:0] mem_addr;
    logic [PW-1:0] mem_wdata;
    logic [PW-1:0] mem_rdata = '0;

    blit_engine #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_en(ch_en), .blend_en(blend_en),
        .serial_mode(serial_mode), .fill_color(fill_color), .chan_base(chan_base),
        .chan_width(chan_width), .chan_stride(chan_stride), .chan_count(chan_count),
        .busy(busy), .done(done), .done_pulse(done_pulse), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0;
    int cycles = 0;
    bit timed_out = 0;
    int wcount = 0, acount = 0, viol_order = 0, viol_rel = 0, viol_gnt = 0;
    logic [PW-1:0] mem  [MSZ];
    logic [PW-1:0] snap [MSZ];

    // memory model, arbiter and protocol monitors (sampled mid-cycle)
    initial begin
        logic [PW-1:0] p1, p2;
        bit prev_we, seen_w;
        p1 = '0; p2 = '0; prev_we = 0; seen_w = 0;
        void'($urandom(32'd4242));
        for (int i = 0; i < MSZ; i++) mem[i] = PW'($urandom());
        forever begin
            @(negedge clk);
            cycles++;
            if ((mem_rd || mem_we) && !mem_gnt) viol_gnt++;
            if (mem_rd && seen_w) viol_order++;
            if (prev_we && !mem_we && mem_req) viol_rel++;
            if (mem_rd || mem_we) acount++;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wcount++;
                seen_w = 1;
            end
            if (!mem_req) seen_w = 0;
            prev_we = mem_we;
            mem_rdata = p2;
            p2 = p1;
            p1 = mem_rd ? mem[mem_addr] : 'x;
            if (!mem_req)          mem_gnt = 0;
            else if (!mem_gnt)     mem_gnt = ($urandom_range(0, 3) == 0);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int addr_of(input int ch, input int j);
        return (int'(chan_base[ch]) + (j / int'(chan_width[ch])) * int'(chan_stride[ch])
                + (j % int'(chan_width[ch]))) % MSZ;
    endfunction

    function automatic logic [PW-1:0] exp_pix(input int k);
        logic [PW-1:0] a, b, c, r;
        a = ch_en[0] ? snap[addr_of(0, k % int'(chan_count[0]))] : '0;
        b = ch_en[1] ? snap[addr_of(1, k % int'(chan_count[1]))] : '0;
        c = ch_en[2] ? snap[addr_of(2, k % int'(chan_count[2]))] : '0;
        if (blend_en) begin
            for (int i = 0; i < PW / 8; i++) begin
                int av, bv, cv;
                av = int'(a[i*8 +: 8]); bv = int'(b[i*8 +: 8]); cv = int'(c[i*8 +: 8]);
                r[i*8 +: 8] = 8'((av * bv + (255 - av) * cv) >> 8);
            end
        end else if (ch_en[0]) r = a;
        else r = fill_color;
        return r;
    endfunction

    // launch a job with the currently set inputs and wait for completion
    task automatic launch(input bit poke_busy);
        for (int i = 0; i < MSZ; i++) snap[i] = mem[i];
        wcount = 0; acount = 0; viol_order = 0; viol_rel = 0; viol_gnt = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        if (poke_busy) begin
            logic [PW-1:0] keep;
            repeat (5) @(negedge clk);
            keep = fill_color;
            fill_color = ~keep; start = 1;
            @(negedge clk); start = 0;
            fill_color = keep;
        end
        while (!done_pulse && !timed_out) @(negedge clk);
    endtask

    task automatic verify(input string req);
        int bad;
        logic [PW-1:0] act, exp;
        bad = 0; act = '0; exp = '0;
        for (int k = 0; k < int'(chan_count[3]); k++) begin
            logic [PW-1:0] e;
            e = exp_pix(k);
            if (mem[addr_of(3, k)] !== e && bad == 0) begin
                act = mem[addr_of(3, k)]; exp = e;
            end
            if (mem[addr_of(3, k)] !== e) bad++;
        end
        check(bad == 0, req, "destination pixel", longint'(act), longint'(exp));
        check(wcount == int'(chan_count[3]), req, "write count", wcount, chan_count[3]);
        check(viol_order == 0, "R6", "read after write in batch", viol_order, 0);
        check(viol_rel == 0 && viol_gnt == 0, "R7", "port release/grant", viol_rel + viol_gnt, 0);
        @(negedge clk);
        check(!done_pulse && done && !busy, "R9", "done flag/pulse after finish",
              {done_pulse, done, busy}, 3'b010);
    endtask

    task automatic set_ch(input int ch, input int b, input int w, input int s, input int c);
        chan_base[ch] = AW'(b); chan_width[ch] = CW'(w);
        chan_stride[ch] = AW'(s); chan_count[ch] = CW'(c);
    endtask

    // watchdog
    initial begin
        while (cycles < 150000) @(negedge clk);
        timed_out = 1;
        errors++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check({busy, done, done_pulse, mem_req, mem_rd, mem_we} == 6'b0, "R1",
              "outputs in reset", {busy, done, done_pulse, mem_req, mem_rd, mem_we}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(!busy && !mem_req, "R1", "idle after reset", {busy, mem_req}, 0);

        // R2: fill, D only
        ch_en = 4'b1000; blend_en = 0; serial_mode = 0; fill_color = 24'h12AB34;
        set_ch(3, 3100, 5, 9, 23);
        launch(0); verify("R2");

        // R3: 4-wide rectangle with pitch 10 to a linear strip
        ch_en = 4'b1001;
        set_ch(0, 40, 4, 10, 12);
        set_ch(3, 3300, 12, 12, 12);
        launch(0); verify("R3");

        // R4: tile a 3-pixel source across 20 pixels (spans two batches)
        set_ch(0, 200, 3, 3, 3);
        set_ch(3, 3400, 7, 16, 20);
        launch(0); verify("R4");

        // R6: 33 pixels -> batches of 16, 16, 1
        set_ch(0, 300, 6, 8, 33);
        set_ch(3, 3600, 11, 11, 33);
        launch(0); verify("R6");

        // R5: blend with directed corner alphas 0x00 and 0xFF
        mem[500] = 24'h00FF80; mem[501] = 24'hFF0040;
        mem[1100] = 24'h1234FF; mem[1101] = 24'hA0B0C0;
        mem[2100] = 24'h55AA77; mem[2101] = 24'h010203;
        ch_en = 4'b1111; blend_en = 1;
        set_ch(0, 500, 2, 2, 2); set_ch(1, 1100, 2, 2, 2);
        set_ch(2, 2100, 2, 2, 2); set_ch(3, 3800, 2, 2, 2);
        launch(0); verify("R5");
        blend_en = 0;

        // R8: overlapping copy dst = src + 1, serial smears, batch moves
        ch_en = 4'b1001; serial_mode = 1;
        set_ch(0, 700, 8, 8, 8); set_ch(3, 701, 8, 8, 8);
        launch(0);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 8; k++) if (mem[701 + k] !== snap[700]) bad++;
            check(bad == 0, "R8", "serial overlap smear mismatches", bad, 0);
        end
        serial_mode = 0;
        set_ch(0, 800, 8, 8, 8); set_ch(3, 801, 8, 8, 8);
        launch(0); verify("R8");

        // R10: zero D count and D disabled
        set_ch(3, 3900, 4, 4, 0);
        for (int i = 0; i < MSZ; i++) snap[i] = mem[i];
        acount = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        check(done_pulse && done && acount == 0, "R10", "zero count immediate done",
              {done_pulse, done, acount[0]}, 3'b110);
        ch_en = 4'b0001; set_ch(3, 3900, 4, 4, 9);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        check(done_pulse && acount == 0, "R10", "D disabled immediate done",
              {done_pulse, acount[0]}, 2'b10);

        // R11: start while busy ignored
        ch_en = 4'b1000; fill_color = 24'h0F0F0F;
        set_ch(3, 3950, 40, 40, 40);
        launch(1); verify("R11");

        // random jobs (fill, copy, tiled copy, blend; batch or serial)
        for (int t = 0; t < 10; t++) begin
            int mode, dc;
            mode = $urandom_range(0, 3);
            dc = $urandom_range(1, 40);
            serial_mode = $urandom_range(0, 1);
            fill_color = PW'($urandom());
            for (int ch = 0; ch < 4; ch++) begin
                int w, c;
                w = $urandom_range(1, 8);
                c = (mode >= 2) ? $urandom_range(1, dc) : dc;
                if (ch == 3) c = dc;
                set_ch(ch, ch * 1024 + $urandom_range(0, 300), w, w + $urandom_range(0, 4), c);
            end
            blend_en = (mode == 3);
            ch_en = (mode == 0) ? 4'b1000 : (mode == 3) ? 4'b1111 : 4'b1001;
            launch(0);
            verify(mode == 0 ? "R2" : mode == 1 ? "R3" : mode == 2 ? "R4" : "R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule